// File: doc/BRIEF.md
# Bipolar Line Alarm Monitor

This block watches a received bipolar line presented as two rails: one rail pulses for a positive mark and the other for a negative mark. Both rails are sampled on the recovered receive clock. The block raises three alarms. Loss of signal means a long run of zeros. Loss of clock means the recovered clock has stopped. A bipolar violation means two marks in a row with the same polarity. A combined output ORs the two loss alarms so that one pin can report either of them.

When zero-substitution mode is on, the block recognises the eight-bit substitution pattern (three zeros, a violation, a correct-polarity pulse, a zero, a second violation, a correct-polarity pulse). The two deliberate violations inside that pattern are masked. Violations are held in an eight-stage window until the whole pattern is known, so the violation output lags the line by a fixed eight receive-clock cycles.

In dual-rail bypass mode the rails carry plain data, and violation reporting is switched off. An active-low test input forces every alarm output high. It does not disturb the counters or the violation tracking behind the outputs.

Top module: `line_alarm_mon`

## Requirements
- R1: A mark is rx_pos high (positive; rx_pos wins if both rails are high) or rx_neg alone high (negative). A mark whose polarity equals that of the previous mark is a violation, and zeros between the two marks do not change this. After reset the previous polarity is negative.
- R2: A violating mark sampled on receive-clock edge n drives bpv high from edge n+8 to edge n+9, for exactly one cycle per violation.
- R3: With zsub_en=1, the two violations of a substitution pattern are not reported. The pattern is 0,0,0,V,B,0,V,B, where V repeats the previous mark's polarity and each B is opposite to the mark before it. Violations outside such a pattern are still reported. With zsub_en=0 every violation is reported.
- R4: With dual_mode=1, bpv never asserts.
- R5: los asserts once 128 consecutive zero samples have been counted. It stays low after 127 zeros and stays high while zeros continue, because the counter saturates.
- R6: A mark clears the zero counter and los on the edge that samples the mark.
- R7: loc asserts after 16 reference-clock cycles with no recovered-clock edge seen (plus two synchronizer cycles). It clears within a few reference cycles of the next edge, regardless of los.
- R8: alm_test_n low forces los, loc, bpv and alarm high at once. Zero counting continues unchanged underneath, so the true state returns when the input is released.
- R9: alarm equals los OR loc as seen at the outputs; bpv does not drive it.
- R10: Reset (rst_n low, asynchronous) clears all counters, the window and all four outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Recovered receive clock |
| refclk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pos | input | 1 | Positive-pulse rail |
| rx_neg | input | 1 | Negative-pulse rail |
| dual_mode | input | 1 | Dual-rail bypass; disables violation reporting |
| zsub_en | input | 1 | Zero-substitution pattern masking enable |
| alm_test_n | input | 1 | Active-low alarm test |
| los | output | 1 | Loss of signal |
| loc | output | 1 | Loss of clock |
| bpv | output | 1 | Bipolar violation pulse |
| alarm | output | 1 | Combined loss alarm |

## Verification
On every cycle, the assertions check these behaviours:
- the zero counter never passes its limit;
- los rises only from a count of 127;
- any sampled mark clears los;
- the stored polarity holds across zeros;
- every bpv pulse traces back to a mark leaving the window;
- loc drops after a seen clock edge.

Only the bench's scenarios can show the rest. The exact eight-cycle violation timing is checked over every four-symbol sequence, and masking is checked for substitution patterns of both polarities, including a broken pattern. The bench also shows the 127/128 threshold, the loss-of-clock timing with a stopped receive clock, and that zero counting carries on while the test input forces the alarms.

// File: rtl/line_alarm_mon.sv
module line_alarm_mon #(
  parameter int LOS_LIMIT   = 128,
  parameter int LOC_LIMIT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic rclk,
  input  logic refclk,
  input  logic rst_n,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic dual_mode,
  input  logic zsub_en,
  input  logic alm_test_n,
  output logic los,
  output logic loc,
  output logic bpv,
  output logic alarm
);

  localparam int DEPTH = 8;
  localparam int ZW = $clog2(LOS_LIMIT + 1);
  localparam int LW = $clog2(LOC_LIMIT + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(LOS_LIMIT);
  localparam logic [LW-1:0] LMAX = LW'(LOC_LIMIT);

  // receive-clock domain
  wire mark_in = rx_pos | rx_neg;
  wire pol_in  = rx_pos;

  logic last_pol;
  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n)       last_pol <= 1'b0;
    else if (mark_in) last_pol <= pol_in;

  wire viol_in = mark_in & (pol_in == last_pol) & ~dual_mode;

  logic [DEPTH-1:0] pm, pp, pv, pk;
  logic [DEPTH-1:0] pk_nx;
  logic             code_hit;

  assign code_hit = zsub_en
                  & ~pm[7] & ~pm[6] & ~pm[5]
                  & pm[4] & pv[4]
                  & pm[3] & (pp[3] != pp[4])
                  & ~pm[2]
                  & pm[1] & (pp[1] == pp[3])
                  & pm[0] & (pp[0] != pp[1]);

  always_comb begin
    pk_nx = {pk[DEPTH-2:0], 1'b0};
    if (code_hit) begin
      pk_nx[5] = 1'b1;
      pk_nx[2] = 1'b1;
    end
  end

  logic bpv_q;
  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      pm <= '0; pp <= '0; pv <= '0; pk <= '0; bpv_q <= 1'b0;
    end else begin
      pm    <= {pm[DEPTH-2:0], mark_in};
      pp    <= {pp[DEPTH-2:0], pol_in};
      pv    <= {pv[DEPTH-2:0], viol_in};
      pk    <= pk_nx;
      bpv_q <= pv[DEPTH-1] & ~pk[DEPTH-1] & ~dual_mode;
    end

  logic [ZW-1:0] zcnt;
  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n)            zcnt <= '0;
    else if (mark_in)      zcnt <= '0;
    else if (zcnt != ZMAX) zcnt <= zcnt + 1'b1;

  wire los_int = (zcnt == ZMAX);

  logic tgl;
  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;

  // reference-clock domain
  logic [SYNC_STAGES:0] sy;
  logic [LW-1:0]        lcnt;
  wire edge_seen = sy[SYNC_STAGES] ^ sy[SYNC_STAGES-1];

  always_ff @(posedge refclk or negedge rst_n)
    if (!rst_n) begin
      sy   <= '0;
      lcnt <= '0;
    end else begin
      sy <= {sy[SYNC_STAGES-1:0], tgl};
      if (edge_seen)         lcnt <= '0;
      else if (lcnt != LMAX) lcnt <= lcnt + 1'b1;
    end

  wire loc_int = (lcnt == LMAX);

  assign los   = los_int | ~alm_test_n;
  assign loc   = loc_int | ~alm_test_n;
  assign bpv   = bpv_q   | ~alm_test_n;
  assign alarm = los | loc;

  AST_ZCNT_BOUND: assert property (@(posedge rclk) disable iff (!rst_n) zcnt <= ZMAX); // R5
  AST_LOS_RISE: assert property (@(posedge rclk) disable iff (!rst_n) $rose(los_int) |-> $past(zcnt) == ZMAX - 1'b1); // R5
  AST_LOS_CLEAR: assert property (@(posedge rclk) disable iff (!rst_n) mark_in |=> !los_int); // R6
  AST_POL_HOLD: assert property (@(posedge rclk) disable iff (!rst_n) !mark_in |=> $stable(last_pol)); // R1
  AST_BPV_SOURCE: assert property (@(posedge rclk) disable iff (!rst_n) bpv_q |-> $past(pm[DEPTH-1] && pv[DEPTH-1])); // R2
  AST_LOC_CLEAR: assert property (@(posedge refclk) disable iff (!rst_n) edge_seen |=> !loc_int); // R7

endmodule

// File: tb/sim_line_alarm_mon.sv
`timescale 1ns/1ps
module sim_line_alarm_mon;
  logic rclk = 0, refclk = 0, rst_n = 0;
  logic rx_pos = 0, rx_neg = 0, dual_mode = 0, zsub_en = 0, alm_test_n = 1;
  logic los, loc, bpv, alarm;
  logic rclk_en = 1;
  int n_checks = 0, n_fail = 0;
  int seq [0:39];
  int seq_len;

  line_alarm_mon u0 (.rclk(rclk), .refclk(refclk), .rst_n(rst_n), .rx_pos(rx_pos),
    .rx_neg(rx_neg), .dual_mode(dual_mode), .zsub_en(zsub_en), .alm_test_n(alm_test_n),
    .los(los), .loc(loc), .bpv(bpv), .alarm(alarm));

  always begin #5; if (rclk_en) rclk = ~rclk; end
  always #3 refclk = ~refclk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rx_pos = 0; rx_neg = 0;
    rst_n = 0;
    @(negedge rclk); @(negedge rclk);
    rst_n = 1;
  endtask

  task automatic drive(int s);
    rx_pos = (s == 1);
    rx_neg = (s == 2);
  endtask

  task automatic tick(int s);
    drive(s);
    @(posedge rclk); @(negedge rclk);
  endtask

  task automatic load_str(string s);
    seq_len = s.len();
    for (int i = 0; i < seq_len; i++)
      seq[i] = (s[i] == "+") ? 1 : (s[i] == "-") ? 2 : 0;
  endtask

  task automatic run_seq(bit zs, bit dm, string tag);
    int ev [0:39];
    int last;
    bit bad;
    int bad_act, bad_exp;
    last = 2;
    for (int k = 0; k < 40; k++) ev[k] = 0;
    for (int k = 0; k < seq_len; k++)
      if (seq[k] != 0) begin
        ev[k] = (seq[k] == last) ? 1 : 0;
        last = seq[k];
      end
    if (zs)
      for (int j = 0; j + 7 < seq_len; j++)
        if (seq[j] == 0 && seq[j+1] == 0 && seq[j+2] == 0 && seq[j+3] != 0 && ev[j+3] == 1 &&
            seq[j+4] != 0 && seq[j+4] != seq[j+3] && seq[j+5] == 0 &&
            seq[j+6] == seq[j+4] && seq[j+7] != 0 && seq[j+7] != seq[j+6]) begin
          ev[j+3] = 2; ev[j+6] = 2;
        end
    if (dm) for (int k = 0; k < 40; k++) ev[k] = 0;
    zsub_en = zs; dual_mode = dm;
    do_reset();
    bad = 0; bad_act = 0; bad_exp = 0;
    for (int c = 0; c < seq_len + 9; c++) begin
      tick(c < seq_len ? seq[c] : 0);
      if (c >= 8 && !bad) begin
        if (bpv !== (ev[c-8] == 1) || alarm !== 1'b0) begin
          bad = 1; bad_act = {alarm, bpv}; bad_exp = (ev[c-8] == 1);
        end
      end
    end
    chk(!bad, tag, bad_act, bad_exp);
  endtask

  initial begin
    #1_800_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lf;
    #2;
    chk(los === 0 && loc === 0 && bpv === 0 && alarm === 0, "R10 reset outputs", {los, loc, bpv, alarm}, 0);
    do_reset();
    chk(los === 0 && loc === 0 && bpv === 0 && alarm === 0, "R10 after release", {los, loc, bpv, alarm}, 0);

    // R1 R2 R4: sweep every four-symbol sequence
    for (int dm = 0; dm < 2; dm++)
      for (int code = 0; code < 81; code++) begin
        int v;
        v = code;
        seq_len = 4;
        for (int i = 0; i < 4; i++) begin seq[i] = v % 3; v = v / 3; end
        run_seq(1'b0, dm[0], dm ? "R4 dual sweep" : "R1/R2 sweep");
      end

    // R3 substitution patterns
    load_str("+000+-0-+000"); run_seq(1, 0, "R3 positive code masked");
    load_str("+000+-0-+000"); run_seq(0, 0, "R3 code reported when off");
    load_str("-+-000-+0+-00"); run_seq(1, 0, "R3 negative code masked");
    load_str("-+-000-+0+-00"); run_seq(0, 0, "R3 negative code off");
    load_str("+000+-00+-00"); run_seq(1, 0, "R3 broken code reported");
    load_str("++000+-0-+++"); run_seq(1, 0, "R3 code among violations");
    load_str("+000+-0-+000"); run_seq(1, 1, "R4 code in dual mode");

    lf = 32'h1ACE;
    for (int r = 0; r < 30; r++) begin
      seq_len = 24;
      for (int i = 0; i < 24; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        seq[i] = (lf[1:0] == 2'd3) ? 0 : (lf[3:2] == 2'd0 ? 0 : lf[1:0] % 3);
      end
      run_seq(r[0], 1'b0, "R3 pseudo-random stream");
    end

    // R5 R6 R8 R9: loss of signal
    zsub_en = 0; dual_mode = 0;
    do_reset();
    for (int c = 0; c < 127; c++) tick(0);
    chk(los === 0, "R5 127 zeros", los, 0);
    tick(0);
    chk(los === 1, "R5 128 zeros", los, 1);
    chk(alarm === 1 && loc === 0, "R9 alarm from los", {alarm, loc}, 2);
    for (int c = 0; c < 40; c++) tick(0);
    chk(los === 1, "R5 saturated", los, 1);
    tick(2);
    chk(los === 0 && alarm === 0, "R6 mark clears", {los, alarm}, 0);
    for (int c = 0; c < 99; c++) tick(0);
    chk(los === 0, "R6 99 zeros after mark", los, 0);
    alm_test_n = 0; #1;
    chk(los === 1 && loc === 1 && bpv === 1 && alarm === 1, "R8 test forces", {los, loc, bpv, alarm}, 15);
    for (int c = 0; c < 20; c++) tick(0);
    alm_test_n = 1; #1;
    chk(los === 0 && bpv === 0, "R8 release", {los, bpv}, 0);
    for (int c = 0; c < 8; c++) tick(0);
    chk(los === 0, "R8 count kept 127", los, 0);
    tick(0);
    chk(los === 1, "R8 count kept 128", los, 1);

    // R7 loss of clock
    do_reset();
    tick(1);
    rclk_en = 0;
    repeat (10) @(posedge refclk);
    @(negedge refclk);
    chk(loc === 0, "R7 not yet", loc, 0);
    repeat (25) @(posedge refclk);
    @(negedge refclk);
    chk(loc === 1 && los === 0, "R7 stopped clock", {loc, los}, 2);
    chk(alarm === 1, "R9 alarm from loc", alarm, 1);
    rclk_en = 1;
    repeat (10) @(posedge refclk);
    @(negedge refclk);
    chk(loc === 0, "R7 clock returns", loc, 0);
    @(negedge rclk);
    do_reset();
    chk(los === 0 && loc === 0 && bpv === 0, "R10 final reset", {los, loc, bpv}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule